// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block keeps a small bank of transmit mailboxes and decides which armed mailbox is handed to the CAN protocol engine next. Each mailbox holds a mode, a 4-bit priority, an identifier word, eight data bytes, a data length code and a remote-request flag. Software fills these through a simple write port and arms the mailbox by writing its control word with the transfer-command bit set. The arbiter then presents the winning frame to the engine and holds it until the engine reports completion or abort.

Selection goes by priority value, with the smallest value the most urgent. Among mailboxes of equal priority, the lowest mailbox number wins. Each mailbox reports a ready flag, an abort flag and a completion interrupt bit, one bit per mailbox in index order. The engine side uses a level handshake: `eng_valid` stays high with a stable frame until a one-cycle `eng_done` or `eng_abort` pulse.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After reset every mailbox reports ready=1, abort=0 and interrupt=0, and `eng_valid` is low.
- R2: A control write (`wr_sel`=4) with bit 23 set, sent to a ready mailbox, clears that mailbox's ready bit on the next cycle. If the engine is idle, `eng_valid` rises one cycle later with `eng_mb` naming that mailbox.
- R3: Among armed transmit-mode mailboxes, the one with the numerically smallest priority (mode word bits 19:16) is presented first.
- R4: When armed mailboxes share the smallest priority, the lowest mailbox number is presented first.
- R5: A mailbox whose mode field (mode word bits 26:24) is not 3 (transmit) is never presented, even when armed. It becomes eligible once its mode is rewritten to 3.
- R6: The presented frame carries the data length code from control bits 19:16 and the remote flag from control bit 20. `eng_data` is {high data word (`wr_sel`=3), low data word (`wr_sel`=2)}.
- R7: For an identifier word (`wr_sel`=1) with bit 29 set, `eng_ext`=1 and `eng_ident` is bits 28:0. With bit 29 clear, `eng_ext`=0 and `eng_ident` is the 11-bit value from bits 28:18, zero-extended.
- R8: An `eng_done` pulse sets the current mailbox's ready and interrupt bits and drops `eng_valid`. Re-arming the mailbox clears its interrupt bit.
- R9: An `eng_abort` pulse sets the current mailbox's ready and abort bits and leaves its interrupt bit clear. Re-arming the mailbox clears its abort bit.
- R10: While a mailbox is being presented, writes to it are ignored and the presented frame stays unchanged.
- R11: A control write without bit 23 does not arm the mailbox. A control write with bit 23 sent to a mailbox whose ready bit is low is ignored entirely, including its length and remote fields.
- R12: An armed mailbox keeps its ready bit low until the engine reports done or abort for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_mb | input | IDX_W | Target mailbox number |
| wr_sel | input | 3 | Register select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| wr_data | input | 32 | Write data |
| eng_done | input | 1 | Engine reports the presented frame was sent |
| eng_abort | input | 1 | Engine reports the presented frame was aborted |
| eng_valid | output | 1 | A frame is presented to the engine |
| eng_mb | output | IDX_W | Number of the presented mailbox |
| eng_ext | output | 1 | Presented identifier is extended |
| eng_ident | output | 29 | Presented identifier, right-aligned |
| eng_rtr | output | 1 | Presented frame is a remote request |
| eng_dlc | output | 4 | Presented data length code |
| eng_data | output | 64 | Presented data bytes |
| mb_ready | output | NUM_MB | Per-mailbox ready flags |
| mb_abort | output | NUM_MB | Per-mailbox abort flags |
| mb_irq | output | NUM_MB | Per-mailbox completion interrupt bits |

## Verification
The assertions assume the engine pulses `eng_done` or `eng_abort` only while `eng_valid` is high, never both in the same cycle, and for one cycle only. The bench meets this by raising a single completion pulse only after it has observed `eng_valid`. Under that assumption the checks cover frame stability during presentation, the flag updates after each completion, and the rule that only transmit-mode mailboxes are presented. To test the ordering rules, the bench first keeps the engine busy with one mailbox and arms the competing mailboxes while it is busy, so that all candidates are pending together at the next selection.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

  localparam int SEL_MODE  = 0;
  localparam int SEL_IDENT = 1;
  localparam int SEL_DLO   = 2;
  localparam int SEL_DHI   = 3;
  localparam int SEL_CTRL  = 4;

  localparam int MODE_LSB    = 24;
  localparam int MODE_W      = 3;
  localparam int PRIO_LSB    = 16;
  localparam int CTRL_REQ    = 23;
  localparam int CTRL_RTR    = 20;
  localparam int CTRL_DLC_LSB = 16;
  localparam int ID_EXT_BIT  = 29;

  localparam logic [MODE_W-1:0] MODE_TX = 3'd3;

  typedef struct packed {
    logic [29:0] idword;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } mb_frame_t;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              in_flight,
  input  logic              fin_done,
  input  logic              fin_abort,
  output logic              is_tx,
  output logic [PRIO_W-1:0] prio,
  output mb_frame_t         frame,
  output logic              ready,
  output logic              abort_flag,
  output logic              done_flag
);

  logic [MODE_W-1:0] mode_q, mode_n;
  logic [PRIO_W-1:0] prio_q, prio_n;
  mb_frame_t         frm_q, frm_n;
  logic              ready_q, ready_n;
  logic              abt_q, abt_n;
  logic              irq_q, irq_n;
  logic              wr_ok;
  logic              arm;

  assign wr_ok = wr_hit && !in_flight;
  assign arm   = wr_ok && (wr_sel == 3'(SEL_CTRL)) && wr_data[CTRL_REQ] && ready_q;

  always_comb begin
    mode_n  = mode_q;
    prio_n  = prio_q;
    frm_n   = frm_q;
    ready_n = ready_q;
    abt_n   = abt_q;
    irq_n   = irq_q;
    if (wr_ok) begin
      case (wr_sel)
        3'(SEL_MODE): begin
          mode_n = wr_data[MODE_LSB +: MODE_W];
          prio_n = wr_data[PRIO_LSB +: PRIO_W];
        end
        3'(SEL_IDENT): frm_n.idword = wr_data[29:0];
        3'(SEL_DLO):   frm_n.data[31:0]  = wr_data;
        3'(SEL_DHI):   frm_n.data[63:32] = wr_data;
        3'(SEL_CTRL): begin
          if (!wr_data[CTRL_REQ] || ready_q) begin
            frm_n.dlc = wr_data[CTRL_DLC_LSB +: 4];
            frm_n.rtr = wr_data[CTRL_RTR];
          end
        end
        default: ;
      endcase
    end
    if (arm) begin
      ready_n = 1'b0;
      abt_n   = 1'b0;
      irq_n   = 1'b0;
    end
    if (in_flight && fin_done) begin
      ready_n = 1'b1;
      irq_n   = 1'b1;
    end else if (in_flight && fin_abort) begin
      ready_n = 1'b1;
      abt_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      prio_q  <= '0;
      frm_q   <= '0;
      ready_q <= 1'b1;
      abt_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      prio_q  <= prio_n;
      frm_q   <= frm_n;
      ready_q <= ready_n;
      abt_q   <= abt_n;
      irq_q   <= irq_n;
    end
  end

  assign is_tx      = (mode_q == MODE_TX);
  assign prio       = prio_q;
  assign frame      = frm_q;
  assign ready      = ready_q;
  assign abort_flag = abt_q;
  assign done_flag  = irq_q;

  AST_ARM_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !in_flight && wr_sel == 3'(SEL_CTRL) && wr_data[CTRL_REQ] && ready_q) |=> !ready_q); // R2
  AST_READY_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && !in_flight) |=> !ready_q); // R12

endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick #(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0]        cand,
  input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
  output logic                     any,
  output logic [IDX_W-1:0]         idx
);

  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    any       = 1'b0;
    idx       = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (cand[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
        any       = 1'b1;
        idx       = IDX_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_mb,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              eng_done,
  input  logic              eng_abort,
  output logic              eng_valid,
  output logic [IDX_W-1:0]  eng_mb,
  output logic              eng_ext,
  output logic [28:0]       eng_ident,
  output logic              eng_rtr,
  output logic [3:0]        eng_dlc,
  output logic [63:0]       eng_data,
  output logic [NUM_MB-1:0] mb_ready,
  output logic [NUM_MB-1:0] mb_abort,
  output logic [NUM_MB-1:0] mb_irq
);

  logic [1:0] rst_sync;
  logic       rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core = rst_sync[1];

  logic                     busy_q, busy_n;
  logic [IDX_W-1:0]         cur_q, cur_n;
  logic [NUM_MB-1:0]        tx_vec;
  logic [NUM_MB-1:0]        cand;
  logic [NUM_MB*PRIO_W-1:0] prio_flat;
  mb_frame_t                frames [NUM_MB];
  logic                     pick_any;
  logic [IDX_W-1:0]         pick_idx;
  logic                     fin_abort;

  assign fin_abort = eng_abort && !eng_done;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    logic in_flight;
    assign in_flight = busy_q && (cur_q == IDX_W'(g));
    can_txmb_slot #(.PRIO_W(PRIO_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_core),
      .wr_hit     (wr_en && (wr_mb == IDX_W'(g))),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .in_flight  (in_flight),
      .fin_done   (eng_done),
      .fin_abort  (fin_abort),
      .is_tx      (tx_vec[g]),
      .prio       (prio_flat[g*PRIO_W +: PRIO_W]),
      .frame      (frames[g]),
      .ready      (mb_ready[g]),
      .abort_flag (mb_abort[g]),
      .done_flag  (mb_irq[g])
    );
    assign cand[g] = tx_vec[g] && !mb_ready[g];
  end

  can_txmb_pick #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_pick (
    .cand      (cand),
    .prio_flat (prio_flat),
    .any       (pick_any),
    .idx       (pick_idx)
  );

  always_comb begin
    busy_n = busy_q;
    cur_n  = cur_q;
    if (busy_q) begin
      if (eng_done || eng_abort) busy_n = 1'b0;
    end else if (pick_any) begin
      busy_n = 1'b1;
      cur_n  = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cur_q  <= cur_n;
    end
  end

  mb_frame_t cur_frm;
  assign cur_frm   = frames[cur_q];
  assign eng_valid = busy_q;
  assign eng_mb    = cur_q;
  assign eng_ext   = cur_frm.idword[ID_EXT_BIT];
  assign eng_ident = cur_frm.idword[ID_EXT_BIT] ? cur_frm.idword[28:0]
                                                : {18'd0, cur_frm.idword[28:18]};
  assign eng_rtr   = cur_frm.rtr;
  assign eng_dlc   = cur_frm.dlc;
  assign eng_data  = cur_frm.data;

  AST_ONLY_TX_MODE: assert property (@(posedge clk) disable iff (!rst_core)
    busy_q |-> tx_vec[cur_q]); // R5
  AST_FLIGHT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_core)
    busy_q |-> !mb_ready[cur_q]); // R12
  AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_core)
    (busy_q && !eng_done && !eng_abort) |=>
      (busy_q && $stable(cur_q) && $stable(eng_data) && $stable(eng_ident) && $stable(eng_dlc))); // R10
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_core)
    (busy_q && eng_done) |=> (mb_irq[$past(cur_q)] && mb_ready[$past(cur_q)] && !busy_q)); // R8
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_core)
    (busy_q && eng_abort && !eng_done) |=> (mb_abort[$past(cur_q)] && !mb_irq[$past(cur_q)])); // R9

endmodule

// File: tb/can_txmb_arbiter_bench.sv
`timescale 1ns/1ps
module can_txmb_arbiter_bench;

  localparam int NUM_MB = 4;
  localparam int IDX_W  = 2;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_mb;
  logic [2:0]        wr_sel;
  logic [31:0]       wr_data;
  logic              eng_done;
  logic              eng_abort;
  logic              eng_valid;
  logic [IDX_W-1:0]  eng_mb;
  logic              eng_ext;
  logic [28:0]       eng_ident;
  logic              eng_rtr;
  logic [3:0]        eng_dlc;
  logic [63:0]       eng_data;
  logic [NUM_MB-1:0] mb_ready;
  logic [NUM_MB-1:0] mb_abort;
  logic [NUM_MB-1:0] mb_irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  can_txmb_arbiter #(.NUM_MB(NUM_MB), .PRIO_W(4)) u_can_txmb_arbiter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mb(wr_mb), .wr_sel(wr_sel),
    .wr_data(wr_data), .eng_done(eng_done), .eng_abort(eng_abort),
    .eng_valid(eng_valid), .eng_mb(eng_mb), .eng_ext(eng_ext), .eng_ident(eng_ident),
    .eng_rtr(eng_rtr), .eng_dlc(eng_dlc), .eng_data(eng_data),
    .mb_ready(mb_ready), .mb_abort(mb_abort), .mb_irq(mb_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int mb, input int sel, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_mb   = IDX_W'(mb);
    wr_sel  = 3'(sel);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [31:0] mode_word(input int mode, input int prio);
    return (32'(mode) << 24) | (32'(prio) << 16);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit req, input bit rtr, input int dlc);
    return (32'(req) << 23) | (32'(rtr) << 20) | (32'(dlc) << 16);
  endfunction

  // pulse done or abort; returns at the negedge where flags are updated
  task automatic finish(input bit abort);
    if (abort) eng_abort = 1'b1; else eng_done = 1'b1;
    @(negedge clk);
    eng_done  = 1'b0;
    eng_abort = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ready", 64'(mb_ready), 64'hF);
    check("R1 abort", 64'(mb_abort), 64'h0);
    check("R1 irq", 64'(mb_irq), 64'h0);
    check("R1 valid", 64'(eng_valid), 64'h0);
  endtask

  task automatic t_basic;
    wr(0, 0, mode_word(3, 5));
    wr(0, 1, 32'h123 << 18);
    wr(0, 2, 32'h44332211);
    wr(0, 3, 32'h88776655);
    wr(0, 4, ctrl_word(1, 0, 8));
    check("R2 ready low", 64'(mb_ready[0]), 64'h0);
    check("R2 valid not yet", 64'(eng_valid), 64'h0);
    @(negedge clk);
    check("R2 valid", 64'(eng_valid), 64'h1);
    check("R2 mb", 64'(eng_mb), 64'h0);
    check("R7 std ext", 64'(eng_ext), 64'h0);
    check("R7 std ident", 64'(eng_ident), 64'h123);
    check("R6 dlc", 64'(eng_dlc), 64'h8);
    check("R6 rtr", 64'(eng_rtr), 64'h0);
    check("R6 data", eng_data, 64'h8877665544332211);
    repeat (3) @(negedge clk);
    check("R12 ready held low", 64'(mb_ready[0]), 64'h0);
    finish(1'b0);
    check("R8 ready", 64'(mb_ready[0]), 64'h1);
    check("R8 irq", 64'(mb_irq[0]), 64'h1);
    check("R8 valid low", 64'(eng_valid), 64'h0);
  endtask

  task automatic t_ext_abort;
    wr(1, 0, mode_word(3, 2));
    wr(1, 1, (32'h1 << 29) | 32'h0ABCDE0F);
    wr(1, 2, 32'hCAFEF00D);
    wr(1, 3, 32'h0);
    wr(1, 4, ctrl_word(1, 1, 3));
    @(negedge clk);
    check("R7 ext flag", 64'(eng_ext), 64'h1);
    check("R7 ext ident", 64'(eng_ident), 64'h0ABCDE0F);
    check("R6 rtr set", 64'(eng_rtr), 64'h1);
    wr(1, 2, 32'hDEADBEEF);
    wr(1, 4, ctrl_word(0, 0, 7));
    check("R10 data held", eng_data, 64'h00000000CAFEF00D);
    check("R10 dlc held", 64'(eng_dlc), 64'h3);
    finish(1'b1);
    check("R9 ready", 64'(mb_ready[1]), 64'h1);
    check("R9 abort", 64'(mb_abort[1]), 64'h1);
    check("R9 irq clear", 64'(mb_irq[1]), 64'h0);
  endtask

  task automatic t_priority;
    wr(0, 0, mode_word(3, 0));
    wr(0, 4, ctrl_word(1, 0, 1));
    check("R8 irq cleared on rearm", 64'(mb_irq[0]), 64'h0);
    @(negedge clk);
    check("R3 blocker", 64'(eng_mb), 64'h0);
    wr(1, 0, mode_word(3, 9));
    wr(2, 0, mode_word(3, 3));
    wr(3, 0, mode_word(3, 3));
    wr(1, 4, ctrl_word(1, 0, 1));
    check("R9 abort cleared on rearm", 64'(mb_abort[1]), 64'h0);
    wr(3, 4, ctrl_word(1, 0, 1));
    wr(2, 4, ctrl_word(1, 0, 1));
    finish(1'b0);
    @(negedge clk);
    check("R3 R4 first pick", 64'(eng_mb), 64'h2);
    finish(1'b0);
    @(negedge clk);
    check("R4 tie second", 64'(eng_mb), 64'h3);
    finish(1'b0);
    @(negedge clk);
    check("R3 lowest last", 64'(eng_mb), 64'h1);
    finish(1'b0);
    check("R8 all ready", 64'(mb_ready), 64'hF);
  endtask

  task automatic t_non_tx;
    wr(0, 0, mode_word(0, 0));
    wr(0, 4, ctrl_word(1, 0, 2));
    check("R5 armed", 64'(mb_ready[0]), 64'h0);
    repeat (3) @(negedge clk);
    check("R5 not presented", 64'(eng_valid), 64'h0);
    wr(0, 4, ctrl_word(1, 1, 7));
    wr(1, 4, ctrl_word(0, 0, 5));
    @(negedge clk);
    check("R11 no arm without bit", 64'(mb_ready[1]), 64'h1);
    check("R11 still idle", 64'(eng_valid), 64'h0);
    wr(0, 0, mode_word(3, 1));
    @(negedge clk);
    check("R5 presented after mode", 64'(eng_valid), 64'h1);
    check("R5 mb", 64'(eng_mb), 64'h0);
    check("R11 dlc kept", 64'(eng_dlc), 64'h2);
    check("R11 rtr kept", 64'(eng_rtr), 64'h0);
    finish(1'b0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_mb = '0; wr_sel = '0; wr_data = '0;
    eng_done = 1'b0; eng_abort = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_ext_abort;
    t_priority;
    t_non_tx;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule